// File: doc/BRIEF.md
# Multi-Mode Backplane Link Transmitter

This block drives a 25-line parallel backplane link that carries one 96-bit payload per bunch period. The payload is cut into four 24-bit words, and each word occupies one of four slots in the period. The block runs on a clock at the slot rate. A slot strobe marks the cycles that advance the link. A bunch strobe, given together with the slot strobe, marks the first slot of a new period. On that strobe the block captures the payload and the 3-bit mode value and holds both for the whole period.

The mode value selects the line format. The first format is a legacy single-rate format that repeats the first word. The second sends inverted words next to a forwarded clock that toggles every slot. Two formats carry a combined framing and parity line, at the low line or at the high line. The last format places a free-running counter on four data lines for link tests. The framing line carries a fixed pattern 1, 1, 0, P across the four slots. P is the odd-parity bit of the 96 payload bits, and a receiver uses this pattern to find frame boundaries.

Top module: `ltx_link_tx`

## Requirements
- R1: While reset is low, and after it until the first slot strobe, all 25 lines are 0.
- R2: Mode 000 (legacy): in every slot, lines 23..0 carry word 0 (payload bits 23..0) and line 24 is 0.
- R3: Mode 001 (forwarded clock): in slot k, lines 24..1 carry the bitwise inverse of word k (payload bits 24k+23..24k). Line 0 is 1 in slots 0 and 2 and 0 in slots 1 and 3.
- R4: Mode 010: in slot k, lines 24..1 carry word k and line 0 carries the framing/parity value.
- R5: Mode 011: in slot k, lines 23..0 carry word k and line 24 carries the framing/parity value.
- R6: The framing/parity value is 1 in slot 0, 1 in slot 1, 0 in slot 2 and the parity bit in slot 3.
- R7: The parity bit makes the count of ones over the 96 payload bits and the parity bit odd.
- R8: Mode 100 (test): lines 11..8 carry a 4-bit counter and every other line is 0. The counter is 0 after reset, advances by one (mod 16) on every slot strobe in any mode, and the value shown in a slot is the count before that slot's advance.
- R9: A cycle without the slot strobe leaves every line unchanged.
- R10: Payload and mode are captured only on a cycle with both strobes. Changes to them at any other time do not affect the current period.
- R11: Mode codes 101, 110 and 111 produce the legacy format of R2.
- R12: The line values of a slot appear one cycle after its slot strobe. The bunch strobe restarts at slot 0, and without a bunch strobe the slot index wraps from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Slot strobe; advances the link by one slot |
| bunch_start | input | 1 | Start of a bunch period, valid with slot_en |
| payload | input | 96 | Four 24-bit words, word k in bits 24k+23..24k |
| mode_cfg | input | 3 | Line format selection |
| line_q | output | 25 | Registered backplane line values |

## Verification
Each mode is run with all-zero, all-one, single-bit and pseudo-random payloads. The all-one and single-bit payloads give opposite parity bits, and the pseudo-random words show whether word order or inversion has gone wrong. Gaps in the slot strobe separate a true hold from a slot that advances anyway. Periods longer than four slots exercise the wrap of the slot index. Runs that change the payload and mode between bunch strobes show whether either value leaks into a period already under way.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    typedef enum logic [2:0] {
        MODE_LEGACY = 3'b000,
        MODE_FWDCLK = 3'b001,
        MODE_CP_LOW = 3'b010,
        MODE_CP_HIGH = 3'b011,
        MODE_TEST   = 3'b100
    } ltx_mode_e;

endpackage

// File: rtl/ltx_parity.sv
module ltx_parity #(
    parameter int W = 96
) (
    input  logic [W-1:0] data,
    output logic         odd_bit
);
    // Bit that makes data plus itself hold an odd number of ones.
    assign odd_bit = ~(^data);
endmodule

// File: rtl/ltx_formatter.sv
module ltx_formatter
    import ltx_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int NWORDS   = 4,
    parameter int CNT_W    = 4,
    parameter int TEST_LSB = 8
) (
    input  logic [2:0]               mode,
    input  logic [$clog2(NWORDS)-1:0] slot,
    input  logic [WORD_W*NWORDS-1:0] payload,
    input  logic                     parity,
    input  logic [CNT_W-1:0]         cnt,
    output logic [WORD_W:0]          line
);
    localparam int SLOT_W = $clog2(NWORDS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NWORDS - 1);

    logic [WORD_W-1:0] words [NWORDS];
    logic [WORD_W-1:0] word_sel;
    logic              marker;

    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_split
        assign words[gi] = payload[gi*WORD_W +: WORD_W];
    end

    assign word_sel = words[slot];

    // Framing pattern: high in the first half, low after, parity in the last slot.
    always_comb begin
        if (slot == LAST_SLOT) marker = parity;
        else                   marker = (int'(slot) < NWORDS / 2);
    end

    always_comb begin
        line = '0;
        case (mode)
            MODE_FWDCLK:  line = {~word_sel, ~slot[0]};
            MODE_CP_LOW:  line = {word_sel, marker};
            MODE_CP_HIGH: line = {marker, word_sel};
            MODE_TEST:    line[TEST_LSB +: CNT_W] = cnt;
            default:      line = {1'b0, words[0]};
        endcase
    end
endmodule

// File: rtl/ltx_link_tx.sv
module ltx_link_tx
    import ltx_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int NWORDS   = 4,
    parameter int CNT_W    = 4,
    parameter int TEST_LSB = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_en,
    input  logic                     bunch_start,
    input  logic [WORD_W*NWORDS-1:0] payload,
    input  logic [2:0]               mode_cfg,
    output logic [WORD_W:0]          line_q
);
    localparam int PAY_W  = WORD_W * NWORDS;
    localparam int SLOT_W = $clog2(NWORDS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NWORDS - 1);

    typedef struct packed {
        logic [PAY_W-1:0]  payload;
        logic [2:0]        mode;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
    } frame_t;

    frame_t          fr_d, fr_q;
    logic [WORD_W:0] line_d;
    logic [WORD_W:0] fmt_line;
    logic            parity_d;

    always_comb begin
        fr_d = fr_q;
        if (slot_en) begin
            fr_d.cnt = fr_q.cnt + 1'b1;
            if (bunch_start) begin
                fr_d.payload = payload;
                fr_d.mode    = mode_cfg;
                fr_d.slot    = '0;
            end else if (fr_q.slot == LAST_SLOT) begin
                fr_d.slot = '0;
            end else begin
                fr_d.slot = fr_q.slot + 1'b1;
            end
        end
    end

    ltx_parity #(.W(PAY_W)) parity_i (
        .data    (fr_d.payload),
        .odd_bit (parity_d)
    );

    ltx_formatter #(
        .WORD_W   (WORD_W),
        .NWORDS   (NWORDS),
        .CNT_W    (CNT_W),
        .TEST_LSB (TEST_LSB)
    ) fmt_i (
        .mode    (fr_d.mode),
        .slot    (fr_d.slot),
        .payload (fr_d.payload),
        .parity  (parity_d),
        .cnt     (fr_q.cnt),
        .line    (fmt_line)
    );

    always_comb begin
        line_d = slot_en ? fmt_line : line_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q   <= '0;
            line_q <= '0;
        end else begin
            fr_q   <= fr_d;
            line_q <= line_d;
        end
    end
endmodule

// File: rtl/ltx_link_tx_chk.sv
module ltx_link_tx_chk #(
    parameter int WORD_W   = 24,
    parameter int CNT_W    = 4,
    parameter int TEST_LSB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_en,
    input logic              bunch_start,
    input logic [WORD_W-1:0] word0,
    input logic [2:0]        mode_cfg,
    input logic [WORD_W:0]   line_q
);
    localparam logic [WORD_W:0] FIELD_M =
        {{(WORD_W + 1 - CNT_W){1'b0}}, {CNT_W{1'b1}}} << TEST_LSB;

    logic start;
    assign start = slot_en && bunch_start;

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(line_q));

    assert_legacy_word0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode_cfg == 3'b000) |=> (line_q == {1'b0, $past(word0)}));

    assert_fwdclk_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode_cfg == 3'b001) |=> (line_q[0] && line_q[WORD_W:1] == ~$past(word0)));

    assert_cp_high_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode_cfg == 3'b011) |=> (line_q[WORD_W] && line_q[WORD_W-1:0] == $past(word0)));

    assert_cp_low_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode_cfg == 3'b010) |=> line_q[0]);

    assert_test_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode_cfg == 3'b100) |=> ((line_q & ~FIELD_M) == '0));
endmodule

bind ltx_link_tx ltx_link_tx_chk #(
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W),
    .TEST_LSB (TEST_LSB)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_en     (slot_en),
    .bunch_start (bunch_start),
    .word0       (payload[WORD_W-1:0]),
    .mode_cfg    (mode_cfg),
    .line_q      (line_q)
);

// File: tb/ltx_link_tx_tb.sv
module ltx_link_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_en = 1'b0;
    logic        bunch_start = 1'b0;
    logic [95:0] payload = '0;
    logic [2:0]  mode_cfg = 3'b000;
    logic [24:0] line_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string ctx  = "";

    always #10 clk = ~clk;

    ltx_link_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_en     (slot_en),
        .bunch_start (bunch_start),
        .payload     (payload),
        .mode_cfg    (mode_cfg),
        .line_q      (line_q)
    );

    // Reference model state
    logic [95:0] m_pay;
    logic [2:0]  m_mode;
    int          m_slot;
    int          m_cnt;
    logic [24:0] m_line;
    bit          m_idle;
    bit          m_live;

    function automatic logic [24:0] ref_line(input logic [2:0] md, input int s,
                                             input logic [95:0] p, input int cnt);
        logic [23:0] w;
        logic [24:0] l;
        int ones;
        logic par, mk;
        ones = 0;
        for (int i = 0; i < 96; i++) if (p[i]) ones++;
        par = (ones % 2 == 0);
        if (s == 3) mk = par;
        else        mk = (s < 2);
        l = '0;
        case (md)
            3'd1: begin w = p[s*24 +: 24]; l = {~w, (s % 2 == 0)}; end
            3'd2: begin w = p[s*24 +: 24]; l = {w, mk}; end
            3'd3: begin w = p[s*24 +: 24]; l = {mk, w}; end
            3'd4: l[11:8] = cnt[3:0];
            default: l = {1'b0, p[23:0]};
        endcase
        return l;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pay <= '0; m_mode <= '0; m_slot <= 0; m_cnt <= 0;
            m_line <= '0; m_idle <= 1'b0; m_live <= 1'b0;
        end else begin
            m_live <= 1'b1;
            m_idle <= !slot_en;
            if (slot_en) begin
                logic [95:0] np;
                logic [2:0]  nm;
                int          ns;
                np = m_pay; nm = m_mode;
                if (bunch_start) begin
                    np = payload; nm = mode_cfg; ns = 0;
                end else begin
                    ns = (m_slot + 1) % 4;
                end
                m_pay  <= np;
                m_mode <= nm;
                m_slot <= ns;
                m_line <= ref_line(nm, ns, np, m_cnt);
                m_cnt  <= (m_cnt + 1) % 16;
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            string tag;
            if (m_idle) tag = "R9";
            else case (m_mode)
                3'd0: tag = "R2 R12";
                3'd1: tag = "R3 R12";
                3'd2: tag = "R4 R6 R7";
                3'd3: tag = "R5 R6 R7";
                3'd4: tag = "R8";
                default: tag = "R11";
            endcase
            n_tests++;
            if (line_q !== m_line) begin
                n_fail++;
                $display("FAIL %s %s: line_q=%h expected=%h", tag, ctx, line_q, m_line);
            end
        end
    end

    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] next_rand(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic drive(input bit se, input bit bs, input logic [95:0] p, input logic [2:0] m);
        slot_en = se; bunch_start = bs; payload = p; mode_cfg = m;
        @(negedge clk);
    endtask

    // Frames: payload and mode valid only on the bunch slot; junk elsewhere.
    task automatic frames(input logic [2:0] m, input logic [95:0] p, input int nslots,
                          input bit gaps, input logic [2:0] junk_mode);
        for (int s = 0; s < nslots; s++) begin
            if (gaps && s == 2) begin
                drive(1'b0, 1'b0, ~p, junk_mode);
                drive(1'b0, 1'b1, p ^ 96'hF0F0, junk_mode);
            end
            if (s == 0) drive(1'b1, 1'b1, p, m);
            else        drive(1'b1, 1'b0, ~p, junk_mode);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [95:0] pats [4];
        repeat (3) @(negedge clk);
        n_tests++;
        if (line_q !== 25'd0) begin
            n_fail++;
            $display("FAIL R1: line_q=%h expected=%h", line_q, 25'd0);
        end
        rst_n = 1'b1;
        drive(1'b0, 1'b0, '0, 3'd0);
        n_tests++;
        if (line_q !== 25'd0) begin
            n_fail++;
            $display("FAIL R1 after release: line_q=%h expected=%h", line_q, 25'd0);
        end

        for (int md = 0; md < 8; md++) begin
            seed = next_rand(seed);
            pats[0] = '0;
            pats[1] = '1;
            pats[2] = 96'h1 << (md * 11);
            pats[3] = {seed, next_rand(seed), next_rand(next_rand(seed))};
            for (int k = 0; k < 4; k++) begin
                frames(3'(md), pats[k], 4, 1'b0, 3'(md));
                frames(3'(md), pats[k] ^ 96'h00ABCD, 4, 1'b1, 3'(md));
            end
            ctx = "R12 wrap";
            frames(3'(md), pats[3], 10, 1'b0, 3'(md));
            ctx = "";
        end

        ctx = "R10";
        for (int md = 0; md < 5; md++) begin
            seed = next_rand(seed);
            frames(3'(md), {seed, ~seed, seed ^ 32'h5A5A5A5A}, 4, 1'b1, 3'((md + 3) % 5));
            frames(3'(md), {~seed, seed, seed}, 5, 1'b0, 3'((md + 1) % 5));
        end
        ctx = "";

        for (int i = 0; i < 40; i++) begin
            seed = next_rand(seed);
            drive(seed[3], seed[4] & seed[5], {3{seed}}, seed[8:6]);
        end
        drive(1'b0, 1'b0, '0, 3'd0);
        drive(1'b0, 1'b0, '0, 3'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule